// File: doc/BRIEF.md
# Zero-Page Indirect, Y-Indexed Address Sequencer

This block runs the bus side of one addressing mode of an 8-bit processor core. The operand is a byte that points into zero page. Two bytes are fetched from that zero-page location to form a 16-bit base address, Y is added to the base, and the final data access goes to the result. The block makes exactly one bus access per clock. In order, it fetches the opcode, the pointer byte, the base low byte and the base high byte, and then makes one or two accesses at the effective address.

When the core pulses `start`, the block samples the operation class (read or store), Y, the accumulator and the program counter. It drives `addr`, `rw` and `wr_data` itself and takes memory data combinationally on `rd_data`. At the end it pulses `done`. In that same cycle it presents the instruction's cycle count, the byte fetched on the final read and the advanced program counter. A free-running dot counter moves forward by a fixed step for every bus cycle, so the host can keep a video timebase in step with the processor.

In the first effective-address cycle the block reads with the high byte not yet corrected. If Y carried out of the low byte, that address is one page too low. Read operations take a sixth cycle only when that carry occurred. Stores always take six cycles and write in the last one.

Top module: `ind_idx_seq`

## Requirements
- R1: Bus cycle 1 reads at the sampled PC and bus cycle 2 reads at PC+1. At `done`, `pc_out` equals PC+2.
- R2: Bus cycle 3 reads at address {0x00, P}, where P is the pointer byte from cycle 2. Bus cycle 4 reads at {0x00, (P+1) mod 256}, so a pointer of 0xFF takes its high byte from 0x0000.
- R3: Bus cycle 5 is a read at {H, (L+Y) mod 256}. L and H are the bytes read in cycles 3 and 4, and H is used without correction.
- R4: A read operation where L+Y < 256 ends after 5 bus cycles. One clock after bus cycle 5, `done` is high for exactly one clock, `cyc_count` is 5 and `data_out` holds the byte read in cycle 5.
- R5: When L+Y ≥ 256, bus cycle 6 goes to {(H+1) mod 256, (L+Y) mod 256}. For a read, `cyc_count` is 6 and `data_out` holds the byte read in cycle 6.
- R6: A store always takes 6 bus cycles, including when Y = 0. Cycle 5 is a read (`rw`=1). Cycle 6 is the only cycle with `rw`=0, and in it `wr_data` carries the sampled accumulator at the corrected address.
- R7: `dot_count` rises by exactly 3 for every clock in which `active` is high and does not change while `active` is low.
- R8: A `start` pulse while `active` is high is ignored: the bus trace and results of the running instruction do not change.
- R9: After reset, `active`=0, `rw`=1, `done`=0 and `dot_count`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an instruction; sampled only while idle |
| is_store | input | 1 | 1 = store operation, 0 = read operation |
| y_val | input | 8 | Index register value |
| acc_val | input | 8 | Byte written by a store |
| pc_in | input | 16 | Address of the opcode |
| rd_data | input | 8 | Memory data for the current address |
| addr | output | 16 | Bus address |
| rw | output | 1 | 1 = read, 0 = write |
| wr_data | output | 8 | Write data, valid when rw = 0 |
| active | output | 1 | High during each bus cycle of an instruction |
| done | output | 1 | One-clock pulse after the last bus cycle |
| cyc_count | output | 3 | Bus cycles used by the last instruction |
| data_out | output | 8 | Byte from the final read cycle |
| pc_out | output | 16 | Program counter after operand fetch |
| dot_count | output | 32 | Running dot count, 3 per bus cycle |

## Verification
The bench checks the full address and direction trace for several kinds of instruction. It covers a read with no carry, including a sum that lands exactly on 0xFF, and a read with a carry, where a design that skipped the correction would return the decoy byte from the page below. A pointer of 0xFF is used because a design that lets the pointer increment leave zero page would fetch the high byte from 0x0100. A store with Y = 0 catches a design that applies read timing to stores and finishes in five cycles without writing. A store whose high byte wraps from 0xFF to 0x00 checks the correction at the top of the address space. A stray `start` in the middle of an instruction would show up as a restarted trace.

// File: rtl/ind_idx_pkg.sv
package ind_idx_pkg;
   typedef enum logic [2:0] {
      S_IDLE  = 3'd0,
      S_OP    = 3'd1,
      S_PTR   = 3'd2,
      S_BLO   = 3'd3,
      S_BHI   = 3'd4,
      S_GUESS = 3'd5,
      S_FIX   = 3'd6
   } seq_state_t;
endpackage

// File: rtl/ind_idx_ptr.sv
module ind_idx_ptr #(
   parameter int AW = 16,
   parameter int DW = 8
) (
   input  logic [DW-1:0] ptr,
   output logic [AW-1:0] lo_addr,
   output logic [AW-1:0] hi_addr
);
   localparam int PAD = AW - DW;
   logic [DW-1:0] ptr_next;

   // increment stays inside the first page
   assign ptr_next = ptr + DW'(1);
   assign lo_addr  = {{PAD{1'b0}}, ptr};
   assign hi_addr  = {{PAD{1'b0}}, ptr_next};
endmodule

// File: rtl/ind_idx_add.sv
module ind_idx_add #(
   parameter int DW = 8
) (
   input  logic [DW-1:0] base_lo,
   input  logic [DW-1:0] idx,
   input  logic [DW-1:0] base_hi,
   input  logic          carry_in,
   output logic [DW-1:0] sum,
   output logic          carry_out,
   output logic [DW-1:0] hi_fixed
);
   assign {carry_out, sum} = {1'b0, base_lo} + {1'b0, idx};
   assign hi_fixed = base_hi + DW'(carry_in);
endmodule

// File: rtl/ind_idx_dots.sv
module ind_idx_dots #(
   parameter int DOT_W = 32,
   parameter int STEP  = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   output logic [DOT_W-1:0] count
);
   generate
      if (STEP == 1) begin : g_unit
         always_ff @(posedge clk) begin
            if (!rst_n)  count <= '0;
            else if (en) count <= count + DOT_W'(1);
         end
      end else begin : g_multi
         localparam logic [DOT_W-1:0] INC = DOT_W'(STEP);
         always_ff @(posedge clk) begin
            if (!rst_n)  count <= '0;
            else if (en) count <= count + INC;
         end
      end
   endgenerate
endmodule

// File: rtl/ind_idx_seq.sv
module ind_idx_seq
   import ind_idx_pkg::*;
#(
   parameter int AW           = 16,
   parameter int DW           = 8,
   parameter int CYC_W        = 3,
   parameter int DOT_W        = 32,
   parameter int DOTS_PER_CYC = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             is_store,
   input  logic [DW-1:0]    y_val,
   input  logic [DW-1:0]    acc_val,
   input  logic [AW-1:0]    pc_in,
   input  logic [DW-1:0]    rd_data,
   output logic [AW-1:0]    addr,
   output logic             rw,
   output logic [DW-1:0]    wr_data,
   output logic             active,
   output logic             done,
   output logic [CYC_W-1:0] cyc_count,
   output logic [DW-1:0]    data_out,
   output logic [AW-1:0]    pc_out,
   output logic [DOT_W-1:0] dot_count
);
   generate
      if (AW != 2 * DW) begin : g_bad_aw
         $error("ind_idx_seq: AW must be twice DW");
      end
      if (CYC_W < 3) begin : g_bad_cyc
         $error("ind_idx_seq: CYC_W too small to hold 6");
      end
      if (DOTS_PER_CYC < 1) begin : g_bad_dots
         $error("ind_idx_seq: DOTS_PER_CYC must be at least 1");
      end
   endgenerate

   seq_state_t       state_q;
   logic [AW-1:0]    pc_q;
   logic [DW-1:0]    y_q, acc_q, ptr_q, blo_q, bhi_q, sum_q, data_q;
   logic             store_q, carry_q, done_q;
   logic [CYC_W-1:0] cnt_q, cyc_q;

   logic [AW-1:0]    zp_lo_addr, zp_hi_addr;
   logic [DW-1:0]    sum_c, hi_fix_c;
   logic             carry_c;

   ind_idx_ptr #(.AW(AW), .DW(DW)) u_ptr (
      .ptr     (ptr_q),
      .lo_addr (zp_lo_addr),
      .hi_addr (zp_hi_addr)
   );

   ind_idx_add #(.DW(DW)) u_add (
      .base_lo   (blo_q),
      .idx       (y_q),
      .base_hi   (bhi_q),
      .carry_in  (carry_q),
      .sum       (sum_c),
      .carry_out (carry_c),
      .hi_fixed  (hi_fix_c)
   );

   ind_idx_dots #(.DOT_W(DOT_W), .STEP(DOTS_PER_CYC)) u_dots (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (active),
      .count (dot_count)
   );

   always_comb begin
      unique case (state_q)
         S_BLO:          addr = zp_lo_addr;
         S_BHI:          addr = zp_hi_addr;
         S_GUESS, S_FIX: addr = {bhi_q, sum_q};
         default:        addr = pc_q;
      endcase
   end

   assign active    = (state_q != S_IDLE);
   assign rw        = !((state_q == S_FIX) && store_q);
   assign wr_data   = rw ? '0 : acc_q;
   assign done      = done_q;
   assign cyc_count = cyc_q;
   assign data_out  = data_q;
   assign pc_out    = pc_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= S_IDLE;
         pc_q    <= '0;
         y_q     <= '0;
         acc_q   <= '0;
         store_q <= 1'b0;
         ptr_q   <= '0;
         blo_q   <= '0;
         bhi_q   <= '0;
         sum_q   <= '0;
         carry_q <= 1'b0;
         done_q  <= 1'b0;
         cnt_q   <= '0;
         cyc_q   <= '0;
         data_q  <= '0;
      end else begin
         done_q <= 1'b0;
         if (active) cnt_q <= cnt_q + CYC_W'(1);
         unique case (state_q)
            S_IDLE: if (start) begin
               pc_q    <= pc_in;
               y_q     <= y_val;
               acc_q   <= acc_val;
               store_q <= is_store;
               cnt_q   <= '0;
               state_q <= S_OP;
            end
            S_OP: begin
               pc_q    <= pc_q + AW'(1);
               state_q <= S_PTR;
            end
            S_PTR: begin
               ptr_q   <= rd_data;
               pc_q    <= pc_q + AW'(1);
               state_q <= S_BLO;
            end
            S_BLO: begin
               blo_q   <= rd_data;
               state_q <= S_BHI;
            end
            S_BHI: begin
               bhi_q   <= rd_data;
               sum_q   <= sum_c;
               carry_q <= carry_c;
               state_q <= S_GUESS;
            end
            S_GUESS: begin
               if (!store_q && !carry_q) begin
                  data_q  <= rd_data;
                  cyc_q   <= cnt_q + CYC_W'(1);
                  done_q  <= 1'b1;
                  state_q <= S_IDLE;
               end else begin
                  bhi_q   <= hi_fix_c;
                  state_q <= S_FIX;
               end
            end
            S_FIX: begin
               if (!store_q) data_q <= rd_data;
               cyc_q   <= cnt_q + CYC_W'(1);
               done_q  <= 1'b1;
               state_q <= S_IDLE;
            end
            default: state_q <= S_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/ind_idx_chk.sv
module ind_idx_chk
   import ind_idx_pkg::*;
#(
   parameter int AW           = 16,
   parameter int DW           = 8,
   parameter int CYC_W        = 3,
   parameter int DOT_W        = 32,
   parameter int DOTS_PER_CYC = 3
) (
   input logic             clk,
   input logic             rst_n,
   input seq_state_t       state_i,
   input logic             store_i,
   input logic             active,
   input logic             rw,
   input logic [AW-1:0]    addr,
   input logic             done,
   input logic [CYC_W-1:0] cyc_count,
   input logic [DOT_W-1:0] dot_count
);
   p_ptr_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
      state_i == S_PTR |-> addr == $past(addr) + AW'(1));

   p_zp_page_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (state_i == S_BLO || state_i == S_BHI) |-> addr[AW-1:DW] == '0);

   p_done_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   p_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (cyc_count == CYC_W'(5) || cyc_count == CYC_W'(6)));

   p_fix_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
      state_i == S_FIX |-> (addr == $past(addr) || addr == $past(addr) + AW'(1 << DW)));

   p_write_only_last_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !rw |-> (active && store_i && state_i == S_FIX));

   p_store_six_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (done && store_i) |-> cyc_count == CYC_W'(6));

   p_dots_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
      active |=> dot_count == $past(dot_count) + DOT_W'(DOTS_PER_CYC));

   p_dots_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !active |=> $stable(dot_count));
endmodule

bind ind_idx_seq ind_idx_chk #(
   .AW(AW), .DW(DW), .CYC_W(CYC_W), .DOT_W(DOT_W), .DOTS_PER_CYC(DOTS_PER_CYC)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .state_i   (state_q),
   .store_i   (store_q),
   .active    (active),
   .rw        (rw),
   .addr      (addr),
   .done      (done),
   .cyc_count (cyc_count),
   .dot_count (dot_count)
);

// File: tb/tb_ind_idx_seq.sv
`timescale 1ns/1ps
module tb_ind_idx_seq;
   logic        clk = 1'b0;
   logic        rst_n, start, is_store;
   logic [7:0]  y_val, acc_val, rd_data, wr_data, data_out;
   logic [15:0] pc_in, addr, pc_out;
   logic        rw, active, done;
   logic [2:0]  cyc_count;
   logic [31:0] dot_count;

   logic [7:0]  mem [0:65535];

   int n_chk  = 0;
   int n_fail = 0;
   bit finished = 1'b0;

   logic [15:0] t_addr [0:7];
   logic        t_rw   [0:7];
   logic [7:0]  t_wd   [0:7];
   int          t_len;
   logic [2:0]  got_cyc;
   logic [7:0]  got_data;
   logic [15:0] got_pc;
   bit          saw_done;

   always #2 clk = ~clk;

   assign rd_data = mem[addr];
   always @(posedge clk) if (active && !rw) mem[addr] <= wr_data;

   ind_idx_seq dut (
      .clk(clk), .rst_n(rst_n), .start(start), .is_store(is_store),
      .y_val(y_val), .acc_val(acc_val), .pc_in(pc_in), .rd_data(rd_data),
      .addr(addr), .rw(rw), .wr_data(wr_data), .active(active), .done(done),
      .cyc_count(cyc_count), .data_out(data_out), .pc_out(pc_out),
      .dot_count(dot_count)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic run_op(input bit st, input logic [7:0] y, input logic [7:0] acc,
                         input logic [15:0] pc, input bit poke);
      @(negedge clk);
      is_store = st; y_val = y; acc_val = acc; pc_in = pc; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      t_len = 0; saw_done = 1'b0;
      for (int k = 0; k < 12 && !saw_done; k++) begin
         if (active && t_len < 8) begin
            t_addr[t_len] = addr; t_rw[t_len] = rw; t_wd[t_len] = wr_data;
            t_len++;
         end
         if (done) begin
            saw_done = 1'b1;
            got_cyc = cyc_count; got_data = data_out; got_pc = pc_out;
         end else begin
            if (poke && k == 1) begin
               start = 1'b1; pc_in = 16'h0000; is_store = ~st; y_val = 8'hFF;
            end
            @(negedge clk);
            start = 1'b0; pc_in = pc; is_store = st; y_val = y;
         end
      end
   endtask

   task automatic do_case(input string name, input bit st, input logic [7:0] y,
                          input logic [7:0] acc, input logic [15:0] pc, input bit poke);
      logic [15:0] e_addr [0:5];
      logic [7:0]  ptr, lo, hi, hi_fix;
      logic [8:0]  sum;
      int          n;
      logic [7:0]  e_data;
      longint      dot0;
      string       tag;
      ptr = mem[pc + 16'd1];
      lo  = mem[{8'h00, ptr}];
      hi  = mem[{8'h00, ptr + 8'd1}];
      sum = {1'b0, lo} + {1'b0, y};
      hi_fix = hi + {7'd0, sum[8]};
      e_addr[0] = pc;
      e_addr[1] = pc + 16'd1;
      e_addr[2] = {8'h00, ptr};
      e_addr[3] = {8'h00, ptr + 8'd1};
      e_addr[4] = {hi, sum[7:0]};
      e_addr[5] = {hi_fix, sum[7:0]};
      n = (st || sum[8]) ? 6 : 5;
      e_data = mem[e_addr[n-1]];
      dot0 = dot_count;
      run_op(st, y, acc, pc, poke);

      tag = st ? "R6" : (n == 6 ? "R5" : "R4");
      chk(saw_done, tag, {name, " done seen"}, saw_done, 1);
      chk(t_len == n, tag, {name, " bus cycle count"}, t_len, n);
      chk(got_cyc == 3'(n), tag, {name, " cyc_count"}, got_cyc, n);
      for (int i = 0; i < n && i < t_len; i++) begin
         string rq;
         bit    e_rw;
         rq = (i < 2) ? "R1" : (i < 4) ? "R2" : (i == 4) ? "R3" : (st ? "R6" : "R5");
         if (poke) rq = "R8";
         e_rw = !(st && i == 5);
         chk(t_addr[i] == e_addr[i], rq, $sformatf("%s addr cycle %0d", name, i + 1),
             t_addr[i], e_addr[i]);
         chk(t_rw[i] == e_rw, st ? "R6" : rq, $sformatf("%s rw cycle %0d", name, i + 1),
             t_rw[i], e_rw);
      end
      chk(got_pc == pc + 16'd2, "R1", {name, " pc_out"}, got_pc, pc + 16'd2);
      if (st) begin
         chk(t_wd[5] == acc, "R6", {name, " write data"}, t_wd[5], acc);
         chk(mem[e_addr[5]] == acc, "R6", {name, " memory written"}, mem[e_addr[5]], acc);
      end else begin
         chk(got_data == e_data, tag, {name, " data_out"}, got_data, e_data);
      end
      chk(dot_count == dot0 + 3 * n, "R7", {name, " dot advance"}, dot_count, dot0 + 3 * n);
   endtask

   task automatic t_reset();
      chk(active == 1'b0, "R9", "reset active", active, 0);
      chk(rw == 1'b1, "R9", "reset rw", rw, 1);
      chk(done == 1'b0, "R9", "reset done", done, 0);
      chk(dot_count == 32'd0, "R9", "reset dot_count", dot_count, 0);
   endtask

   task automatic t_idle_hold();
      longint d0;
      d0 = dot_count;
      repeat (5) @(negedge clk);
      chk(dot_count == d0, "R7", "idle dot hold", dot_count, d0);
      chk(done == 1'b0, "R4", "done idle low", done, 0);
   endtask

   initial begin
      for (int a = 0; a < 65536; a++) mem[a] = 8'h00;
      rst_n = 1'b0; start = 1'b0; is_store = 1'b0;
      y_val = '0; acc_val = '0; pc_in = '0;
      // no carry read
      mem[16'h0200] = 8'hB1; mem[16'h0201] = 8'h40;
      mem[16'h0040] = 8'h20; mem[16'h0041] = 8'h30; mem[16'h3030] = 8'h5A;
      // carry read with decoy below
      mem[16'h0300] = 8'hB1; mem[16'h0301] = 8'h50;
      mem[16'h0050] = 8'h30; mem[16'h0051] = 8'h12;
      mem[16'h1220] = 8'h11; mem[16'h1320] = 8'hC3;
      // pointer at top of zero page
      mem[16'h0400] = 8'hB1; mem[16'h0401] = 8'hFF;
      mem[16'h00FF] = 8'h44; mem[16'h0000] = 8'h56; mem[16'h0100] = 8'h99;
      mem[16'h5645] = 8'h77;
      // store, index zero
      mem[16'h0500] = 8'h91; mem[16'h0501] = 8'h60;
      mem[16'h0060] = 8'h00; mem[16'h0061] = 8'h06; mem[16'h0600] = 8'h7F;
      // store, high byte wraps
      mem[16'h0700] = 8'h91; mem[16'h0701] = 8'h70;
      mem[16'h0070] = 8'h80; mem[16'h0071] = 8'hFF; mem[16'hFF10] = 8'hEE;
      // read, sum lands on 0xFF exactly
      mem[16'h0800] = 8'hB1; mem[16'h0801] = 8'h80;
      mem[16'h0080] = 8'hF0; mem[16'h0081] = 8'h22; mem[16'h22FF] = 8'h6B;

      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();

      do_case("no_cross",    1'b0, 8'h10, 8'h00, 16'h0200, 1'b0);
      do_case("cross",       1'b0, 8'hF0, 8'h00, 16'h0300, 1'b0);
      do_case("ptr_ff",      1'b0, 8'h01, 8'h00, 16'h0400, 1'b0);
      do_case("store_y0",    1'b1, 8'h00, 8'h87, 16'h0500, 1'b0);
      do_case("store_wrap",  1'b1, 8'h90, 8'h3C, 16'h0700, 1'b0);
      do_case("sum_ff",      1'b0, 8'h0F, 8'h00, 16'h0800, 1'b0);
      t_idle_hold();
      do_case("start_ignored", 1'b0, 8'hF0, 8'h00, 16'h0300, 1'b1);

      if (!finished) begin
         finished = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         n_chk++; n_fail++;
         $display("FAIL watchdog run did not complete actual=0 expected=1");
         $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
         $finish;
      end
   end
endmodule